// File: doc/BRIEF.md
# End-of-Interrupt Sweep with Re-assertion Throttle

This block sits next to a 24-entry interrupt routing table. When an end-of-interrupt notice arrives carrying an 8-bit vector, it sweeps the table one entry per clock. For each level-sensitive entry that holds the same vector and still has its "in service" (remote IRR) flag set, it clears that flag. If such an entry is unmasked and its input line is still pending, the line must be delivered again, and the block raises an immediate service request for it.

A guest that acknowledges a level interrupt without quieting the source would cause an endless storm of re-deliveries. To stop this, the block keeps a per-pin count of back-to-back re-assertions caused by end-of-interrupt. Once the count reaches a threshold, the immediate request is dropped, the count restarts, and a single delay timer is armed. When the timer expires, one scan request pulse asks the surrounding logic to rescan the table. A software write to an entry restarts that pin's count. Building the delivered message is left to other logic.

Top module: `eoi_storm_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `eoi_busy`, `rirr_clr`, `svc_req` and `scan_req` are low, and every per-pin count is zero.
- R2: `eoi_valid` is taken only while `eoi_busy` is low. From the next cycle `eoi_busy` stays high for exactly NPINS cycles while `tab_idx` steps 0, 1, ..., NPINS-1, one value per cycle. A strobe raised while busy is ignored.
- R3: During the sweep, `rirr_clr` is high in the cycle showing entry `tab_idx` exactly when `tab_level`=1 (level), `tab_rirr`=1 and `tab_vector` equals the latched vector. All other entries are left alone.
- R4: For a cleared entry with `tab_masked`=0 and `pending[tab_idx]`=1, the pin's count rises by one. If the new count is below STORM_MAX, `svc_req` is high in that same cycle.
- R5: For a cleared entry that is masked or no longer pending, the pin's count returns to zero and `svc_req` stays low.
- R6: When the incremented count would reach STORM_MAX, the count returns to zero, `svc_req` stays low, and a deferral is raised.
- R7: A `cfg_wr` pulse with `cfg_idx` returns that pin's count to zero.
- R8: A deferral arms the timer for DELAY_TICKS cycles in which `tick` is high. At expiry, `scan_req` pulses high for one cycle. A deferral made while the timer is already armed keeps the earlier expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | VEC_W | Vector carried by the strobe |
| eoi_busy | output | 1 | Sweep in progress; strobes ignored |
| tab_idx | output | IDX_W | Table entry being examined |
| tab_vector | input | VEC_W | Vector field of entry `tab_idx` |
| tab_level | input | 1 | 1 = level-sensitive entry |
| tab_masked | input | 1 | 1 = entry masked |
| tab_rirr | input | 1 | Remote IRR flag of the entry |
| rirr_clr | output | 1 | Clear remote IRR of entry `tab_idx` |
| pending | input | NPINS | Per-pin pending bits |
| cfg_wr | input | 1 | Software wrote a table entry |
| cfg_idx | input | IDX_W | Entry written |
| tick | input | 1 | Timebase tick for the delay timer |
| svc_req | output | 1 | Re-service entry `tab_idx` now |
| scan_req | output | 1 | One-cycle pulse at delay expiry |

## Verification
The bench goes after the sweep's filters: entries that are edge-sensitive, that carry another vector, or whose remote IRR is already clear. A design that ignored any of these would clear flags it must not touch. It drives masked and non-pending pins, so that a count which failed to restart would defer too early. It also runs a pin up to the threshold, so that a design which kept re-delivering, or which did not restart the count, shows a request at the wrong time. A second deferral is raised while the timer is armed, which exposes a timer that restarts (a late pulse) or fires twice. A strobe injected mid-sweep and a write to an entry that is close to the threshold show whether the design wrongly takes the strobe or wrongly keeps the count.

// File: rtl/eoi_storm_pkg.sv
package eoi_storm_pkg;
  typedef enum logic {W_IDLE, W_SCAN} walk_st_t;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/eoi_walker.sv
module eoi_walker
  import eoi_storm_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int VEC_W = 8,
  localparam int IW = idx_w(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [VEC_W-1:0] vec_in,
  output logic             busy,
  output logic [IW-1:0]    idx,
  output logic [VEC_W-1:0] vec_q
);
  walk_st_t         st_q, st_n;
  logic [IW-1:0]    idx_q, idx_n;
  logic [VEC_W-1:0] vec_n;
  logic             last;

  assign last = (idx_q == IW'(NPINS - 1));

  always_comb begin
    st_n  = st_q;
    idx_n = idx_q;
    vec_n = vec_q;
    if (st_q == W_IDLE) begin
      if (strobe) begin
        st_n  = W_SCAN;
        idx_n = '0;
        vec_n = vec_in;
      end
    end else if (last) begin
      st_n  = W_IDLE;
      idx_n = '0;
    end else begin
      idx_n = idx_q + IW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= W_IDLE;
      idx_q <= '0;
      vec_q <= '0;
    end else begin
      st_q  <= st_n;
      idx_q <= idx_n;
      vec_q <= vec_n;
    end
  end

  assign busy = (st_q == W_SCAN);
  assign idx  = idx_q;

  a_r2_walk_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && idx_q == $past(idx_q) + IW'(1)));
  a_r2_walk_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last) |=> !busy);
endmodule

// File: rtl/eoi_storm_bank.sv
module eoi_storm_bank
  import eoi_storm_pkg::*;
#(
  parameter int NPINS     = 24,
  parameter int STORM_MAX = 10000,
  localparam int IW = idx_w(NPINS),
  localparam int CW = $clog2(STORM_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [IW-1:0] upd_idx,
  input  logic          live,
  input  logic          wr,
  input  logic [IW-1:0] wr_idx,
  output logic          fire_now,
  output logic          defer
);
  localparam logic [CW-1:0] LIMIT = CW'(STORM_MAX);

  logic [CW-1:0] cnt_q [NPINS];
  logic [CW-1:0] cur, inc;
  logic          hit;

  always_comb begin
    cur      = cnt_q[upd_idx];
    inc      = cur + CW'(1);
    hit      = (inc >= LIMIT);
    fire_now = upd && live && !hit;
    defer    = upd && live && hit;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [CW-1:0] r_q, r_n;
    logic          en;

    always_comb begin
      en  = 1'b0;
      r_n = r_q;
      if (wr && wr_idx == IW'(g)) begin
        en  = 1'b1;
        r_n = '0;
      end else if (upd && upd_idx == IW'(g)) begin
        en  = 1'b1;
        r_n = (live && !hit) ? inc : '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  r_q <= '0;
      else if (en) r_q <= r_n;
    end

    assign cnt_q[g] = r_q;

    a_r6_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
      r_q < LIMIT);
    a_r7_write_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wr_idx == IW'(g)) |=> (r_q == '0));
  end
endmodule

// File: rtl/eoi_defer_timer.sv
module eoi_defer_timer #(
  parameter int DELAY_TICKS = 10000,
  localparam int TW = $clog2(DELAY_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic defer,
  input  logic tick,
  output logic armed,
  output logic scan_req
);
  logic          armed_n, pulse_q, pulse_n;
  logic [TW-1:0] rem_q, rem_n;

  always_comb begin
    armed_n = armed;
    rem_n   = rem_q;
    pulse_n = 1'b0;
    if (armed && tick) begin
      if (rem_q == TW'(1)) begin
        armed_n = 1'b0;
        pulse_n = 1'b1;
      end else begin
        rem_n = rem_q - TW'(1);
      end
    end
    if (defer && !armed_n) begin
      armed_n = 1'b1;
      rem_n   = TW'(DELAY_TICKS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      rem_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      armed   <= armed_n;
      rem_q   <= rem_n;
      pulse_q <= pulse_n;
    end
  end

  assign scan_req = pulse_q;

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    scan_req |=> !scan_req);
  a_r8_defer_arms: assert property (@(posedge clk) disable iff (!rst_n)
    defer |=> armed);
endmodule

// File: rtl/eoi_storm_ctrl.sv
module eoi_storm_ctrl
  import eoi_storm_pkg::*;
#(
  parameter int NPINS       = 24,
  parameter int VEC_W       = 8,
  parameter int STORM_MAX   = 10000,
  parameter int DELAY_TICKS = 10000,
  localparam int IDX_W = idx_w(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eoi_valid,
  input  logic [VEC_W-1:0] eoi_vector,
  output logic             eoi_busy,
  output logic [IDX_W-1:0] tab_idx,
  input  logic [VEC_W-1:0] tab_vector,
  input  logic             tab_level,
  input  logic             tab_masked,
  input  logic             tab_rirr,
  output logic             rirr_clr,
  input  logic [NPINS-1:0] pending,
  input  logic             cfg_wr,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             tick,
  output logic             svc_req,
  output logic             scan_req
);
  logic [VEC_W-1:0] vec_q;
  logic             match, live, defer, armed;

  eoi_walker #(.NPINS(NPINS), .VEC_W(VEC_W)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (eoi_valid),
    .vec_in (eoi_vector),
    .busy   (eoi_busy),
    .idx    (tab_idx),
    .vec_q  (vec_q)
  );

  assign match    = eoi_busy && tab_level && tab_rirr && (tab_vector == vec_q);
  assign live     = !tab_masked && pending[tab_idx];
  assign rirr_clr = match;

  eoi_storm_bank #(.NPINS(NPINS), .STORM_MAX(STORM_MAX)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (match),
    .upd_idx  (tab_idx),
    .live     (live),
    .wr       (cfg_wr),
    .wr_idx   (cfg_idx),
    .fire_now (svc_req),
    .defer    (defer)
  );

  eoi_defer_timer #(.DELAY_TICKS(DELAY_TICKS)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .defer    (defer),
    .tick     (tick),
    .armed    (armed),
    .scan_req (scan_req)
  );

  a_r3_clear_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    rirr_clr |-> eoi_busy);
  a_r4_service_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> rirr_clr);
  a_r6_defer_excludes_service: assert property (@(posedge clk) disable iff (!rst_n)
    defer |-> !svc_req);
  a_r8_pulse_after_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_req) |-> $past(armed));
endmodule

// File: tb/sim_eoi_storm_ctrl.sv
module sim_eoi_storm_ctrl;
  localparam int NP = 24;
  localparam int SMAX = 3;
  localparam int DLY = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eoi_valid = 1'b0;
  logic [7:0] eoi_vector = '0;
  logic eoi_busy, rirr_clr, svc_req, scan_req;
  logic [4:0] tab_idx;
  logic [7:0] tab_vector;
  logic tab_level, tab_masked, tab_rirr;
  logic [NP-1:0] pending = '0;
  logic cfg_wr = 1'b0;
  logic [4:0] cfg_idx = '0;
  logic tick_en = 1'b0;

  logic [NP-1:0] rirr_set = '0, obs_clr = '0, obs_svc = '0;
  int cyc = 0, busy_cycles = 0, idx_err = 0, scans = 0, scan_at = 0, last_strobe = 0;
  int checks = 0, failures = 0;
  int m_cnt [NP];

  // rows: {eoi vector, pending pattern, remote IRR pattern}
  localparam logic [55:0] ROWS [9] = '{
    {8'h40, 24'hFFFFFF, 24'hFFFFFF},
    {8'h41, 24'h0F0F0F, 24'hFFFFFF},
    {8'h42, 24'hFFFFFF, 24'h00FFF0},
    {8'h40, 24'h000000, 24'hFFFFFF},
    {8'h40, 24'hFFFFFF, 24'hFFFFFF},
    {8'h40, 24'hFFFFFF, 24'hFFFFFF},
    {8'h40, 24'hAAAAAA, 24'h555555},
    {8'h77, 24'hFFFFFF, 24'hFFFFFF},
    {8'h40, 24'hFFFFFF, 24'hFFFFFF}
  };

  always #4 clk = ~clk;

  function automatic logic [7:0] cfg_vec(input int i); return 8'h40 + 8'(i % 3); endfunction
  function automatic logic cfg_lvl(input int i); return (i % 4) != 3; endfunction
  function automatic logic cfg_msk(input int i); return (i % 5) == 1; endfunction

  assign tab_vector = cfg_vec(int'(tab_idx));
  assign tab_level  = cfg_lvl(int'(tab_idx));
  assign tab_masked = cfg_msk(int'(tab_idx));
  assign tab_rirr   = rirr_set[tab_idx] & ~obs_clr[tab_idx];

  eoi_storm_ctrl #(.NPINS(NP), .VEC_W(8), .STORM_MAX(SMAX), .DELAY_TICKS(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .eoi_busy(eoi_busy), .tab_idx(tab_idx), .tab_vector(tab_vector),
    .tab_level(tab_level), .tab_masked(tab_masked), .tab_rirr(tab_rirr),
    .rirr_clr(rirr_clr), .pending(pending), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .tick(tick_en), .svc_req(svc_req), .scan_req(scan_req)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (rirr_clr) obs_clr[tab_idx] = 1'b1;
      if (svc_req) obs_svc[tab_idx] = 1'b1;
      if (eoi_busy) begin
        if (int'(tab_idx) != busy_cycles) idx_err++;
        busy_cycles++;
      end
      if (scan_req) begin
        scans++;
        scan_at = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(!eoi_busy && !rirr_clr && !svc_req && !scan_req, "R1", "outputs in reset",
        {eoi_busy, rirr_clr, svc_req, scan_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!eoi_busy && !scan_req, "R1", "outputs after reset", {eoi_busy, scan_req}, 0);
    for (int i = 0; i < NP; i++) m_cnt[i] = 0;
    scans = 0;
    tick_en = 1'b1;
  endtask

  task automatic run_eoi(input logic [7:0] v, input logic [NP-1:0] pend,
                         input logic [NP-1:0] rirr, input bit inject);
    logic [NP-1:0] exp_clr, exp_svc;
    exp_clr = '0;
    exp_svc = '0;
    for (int i = 0; i < NP; i++) begin
      if (cfg_lvl(i) && cfg_vec(i) == v && rirr[i]) begin
        exp_clr[i] = 1'b1;
        if (!cfg_msk(i) && pend[i]) begin
          m_cnt[i]++;
          if (m_cnt[i] >= SMAX) m_cnt[i] = 0;
          else exp_svc[i] = 1'b1;
        end else begin
          m_cnt[i] = 0;
        end
      end
    end
    @(negedge clk);
    pending = pend;
    rirr_set = rirr;
    obs_clr = '0;
    obs_svc = '0;
    busy_cycles = 0;
    idx_err = 0;
    eoi_vector = v;
    eoi_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eoi_valid = 1'b0;
    last_strobe = cyc;
    if (inject) begin
      repeat (3) @(negedge clk);
      eoi_vector = v + 8'd1;
      eoi_valid = 1'b1;
      @(negedge clk);
      eoi_valid = 1'b0;
    end
    while (eoi_busy) @(negedge clk);
    @(negedge clk);
    chk(obs_clr == exp_clr, "R3", "cleared entries", obs_clr, exp_clr);
    chk(obs_svc == exp_svc, "R4 R5 R6", "serviced entries", obs_svc, exp_svc);
    chk(busy_cycles == NP && idx_err == 0, "R2", "sweep length and order",
        busy_cycles, NP);
  endtask

  task automatic cfg_write(input int i);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_idx = 5'(i);
    @(negedge clk);
    cfg_wr = 1'b0;
    m_cnt[i] = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s0, t0;
    do_reset();

    // R3 R4 R5 R6: table of vectors, pending and remote IRR patterns
    for (int r = 0; r < 9; r++)
      run_eoi(ROWS[r][55:48], ROWS[r][47:24], ROWS[r][23:0], 1'b0);

    // R2: strobe during sweep is ignored
    run_eoi(8'h42, 24'hFFFFFF, 24'hFFFFFF, 1'b1);

    // R6 R8: storm on pin 0 (vector 40) and pin 4 (vector 41)
    do_reset();
    run_eoi(8'h40, 24'h000011, 24'hFFFFFF, 1'b0);
    run_eoi(8'h40, 24'h000011, 24'hFFFFFF, 1'b0);
    run_eoi(8'h41, 24'h000011, 24'hFFFFFF, 1'b0);
    run_eoi(8'h41, 24'h000011, 24'hFFFFFF, 1'b0);
    s0 = scans;
    run_eoi(8'h40, 24'h000011, 24'hFFFFFF, 1'b0);
    t0 = last_strobe;
    chk(obs_svc[0] == 1'b0, "R6", "pin 0 deferred", obs_svc[0], 0);
    run_eoi(8'h41, 24'h000011, 24'hFFFFFF, 1'b0);
    chk(obs_svc[4] == 1'b0, "R6", "pin 4 deferred", obs_svc[4], 0);
    repeat (DLY + 60) @(negedge clk);
    chk(scans - s0 == 1, "R8", "scan pulses", scans - s0, 1);
    chk(scan_at - t0 >= DLY && scan_at - t0 <= DLY + 2, "R8", "expiry kept from first deferral",
        scan_at - t0, DLY + 1);

    // R7: write restarts the count of pin 0
    run_eoi(8'h40, 24'h000001, 24'hFFFFFF, 1'b0);
    run_eoi(8'h40, 24'h000001, 24'hFFFFFF, 1'b0);
    cfg_write(0);
    s0 = scans;
    run_eoi(8'h40, 24'h000001, 24'hFFFFFF, 1'b0);
    chk(obs_svc[0] == 1'b1, "R7", "pin 0 serviced after write", obs_svc[0], 1);
    repeat (DLY + 10) @(negedge clk);
    chk(scans == s0, "R7", "no deferral after write", scans - s0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule